// File: doc/BRIEF.md
# Byte-wide PHY Test-Port Register Interface

This block is the configuration side of a PHY test port. An outside agent moves four slow, software-paced pins: a clear, a test clock, a test enable and an 8-bit data bus. The block samples these pins into the system clock domain and finds the clock edges there. It keeps an 8-bit current code and a small register bank. The bank holds one clock-lane control byte, one high-speed receive control byte per data lane and one byte that sets the data-lane settle time.

Access takes two phases. A falling test-clock edge seen while enable is high loads the data bus as the current code. A later rising edge seen while enable is low stores the data bus into the register that the current code selects. The read bus always shows the register at the current code. A matching master is part of the block. It turns one code/data request into the correct pin waveform and holds each level for a set number of system cycles. Its pins are brought out so that the integrator can route them to the slave pins or to an external port.

Top module: `tport_if`

## Requirements
- R1: After the synchronous reset every bank register, the current code and the read bus are 0, the normal-operation flag is 1, the master is ready and its pins rest at test clock 1 and enable 0.
- R2: A falling edge of the test clock while test enable is high loads the data bus as the current code, and the read bus then shows the register at that code.
- R3: A rising edge of the test clock while test enable is low writes the data bus into the register selected by the current code.
- R4: A falling edge while enable is low leaves the current code unchanged, and a rising edge while enable is high writes no register.
- R5: Code 0x34 selects the clock-lane control. Codes 0x44, 0x54, 0x84 and 0x94 select the control bytes of data lanes 0 to 3 (bits [7:0] to [31:24] of the lane output). Code 0x75 selects the settle control.
- R6: A code outside the six of R5 reads 0 on the read bus. A write to such a code changes no register.
- R7: While test clear is high, the register bank and the current code are cleared to 0.
- R8: The normal-operation flag is 1 exactly when the current code is 0x00.
- R9: For each accepted request the master produces these pin events in this order: enable rises, then the test clock falls with the code on the data pins, then enable falls, then the test clock rises with the data on the data pins. No two of the clock and enable pins change in the same cycle.
- R10: The master accepts a request only while ready, drops ready in the cycle after it accepts, and returns to ready with its pins at their rest levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master write request |
| req_code | input | 8 | Register code for the request |
| req_data | input | 8 | Data for the request |
| req_ready | output | 1 | Master idle, can accept a request |
| m_tclk | output | 1 | Master test clock pin |
| m_ten | output | 1 | Master test enable pin |
| m_tdin | output | 8 | Master data pins |
| s_tclr | input | 1 | Slave test clear pin |
| s_tclk | input | 1 | Slave test clock pin |
| s_ten | input | 1 | Slave test enable pin |
| s_tdin | input | 8 | Slave data pins |
| s_tdout | output | 8 | Register at the current code, 0 if not implemented |
| clk_lane_ctl | output | 8 | Clock-lane control register |
| data_lane_ctl | output | 32 | Data-lane control registers, lane n at bits [8n+7:8n] |
| settle_ctl | output | 8 | Settle-time control register |
| normal_op | output | 1 | Current code is 0x00 |

## Verification
Most stimulus is random master writes. Their codes are drawn mostly from the six implemented codes and 0x00, and sometimes from the full byte range. This tells correct address decode apart from aliasing, and it shows that writes to unused codes are dropped. Directed pin sequences driven straight into the slave pins check the two invalid edge and enable pairings. They also load a code without going through the master, which tells edge-and-level qualification apart from plain edge detection. A clear pulse in the middle of the run shows that test clear empties the whole bank and not only the code. During every master request the bench follows the pin events and checks their order and the data-bus value at each clock edge.

// File: rtl/tport_pkg.sv
package tport_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_LANES = 4;
  localparam int N_SLOTS = N_LANES + 2;
  localparam int SLOT_W  = $clog2(N_SLOTS + 1);

  localparam logic [BYTE_W-1:0] CODE_NORMAL = 8'h00;
  localparam logic [BYTE_W-1:0] CODE_CLKLN  = 8'h34;
  localparam logic [BYTE_W-1:0] CODE_LANE0  = 8'h44;
  localparam logic [BYTE_W-1:0] CODE_LANE1  = 8'h54;
  localparam logic [BYTE_W-1:0] CODE_LANE2  = 8'h84;
  localparam logic [BYTE_W-1:0] CODE_LANE3  = 8'h94;
  localparam logic [BYTE_W-1:0] CODE_SETTLE = 8'h75;

  // slot 0: clock lane, slots 1..N_LANES: data lanes, last slot: settle
  localparam logic [SLOT_W-1:0] SLOT_CLK    = '0;
  localparam logic [SLOT_W-1:0] SLOT_SETTLE = SLOT_W'(N_SLOTS - 1);
  localparam logic [SLOT_W-1:0] SLOT_NONE   = '1;

  function automatic logic [SLOT_W-1:0] code_to_slot(input logic [BYTE_W-1:0] code);
    logic [SLOT_W-1:0] s;
    case (code)
      CODE_CLKLN:  s = SLOT_CLK;
      CODE_LANE0:  s = SLOT_W'(1);
      CODE_LANE1:  s = SLOT_W'(2);
      CODE_LANE2:  s = SLOT_W'(3);
      CODE_LANE3:  s = SLOT_W'(4);
      CODE_SETTLE: s = SLOT_SETTLE;
      default:     s = SLOT_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/tport_sync.sv
module tport_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tport_bank.sv
module tport_bank
  import tport_pkg::*;
#(
  parameter int DW     = BYTE_W,
  parameter int LANES  = N_LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_s,
  input  logic              tclk_s,
  input  logic              ten_s,
  input  logic [DW-1:0]     din_s,
  output logic [DW-1:0]     tdout,
  output logic [DW-1:0]     clk_lane_ctl,
  output logic [LANES*DW-1:0] data_lane_ctl,
  output logic [DW-1:0]     settle_ctl,
  output logic              normal_op
);
  localparam int NS = LANES + 2;

  logic              tclk_p;
  logic              rise, fall;
  logic [DW-1:0]     code_q;
  logic [DW-1:0]     slot_q [NS];
  logic [SLOT_W-1:0] sel;
  logic [DW-1:0]     rd_val;

  always_ff @(posedge clk) begin
    if (rst) tclk_p <= 1'b1;
    else     tclk_p <= tclk_s;
  end

  assign rise = tclk_s & ~tclk_p;
  assign fall = ~tclk_s & tclk_p;
  assign sel  = code_to_slot(code_q);

  always_ff @(posedge clk) begin
    if (rst || clr_s) begin
      code_q <= '0;
      for (int i = 0; i < NS; i++) slot_q[i] <= '0;
    end else begin
      if (fall && ten_s) code_q <= din_s;
      if (rise && !ten_s && sel != SLOT_NONE) slot_q[sel] <= din_s;
    end
  end

  always_comb begin
    rd_val = '0;
    if (sel != SLOT_NONE) rd_val = slot_q[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tdout     <= '0;
      normal_op <= 1'b1;
    end else begin
      tdout     <= rd_val;
      normal_op <= (code_q == CODE_NORMAL);
    end
  end

  assign clk_lane_ctl = slot_q[SLOT_CLK];
  assign settle_ctl   = slot_q[NS-1];
  for (genvar g = 0; g < LANES; g++) begin : g_lane_out
    assign data_lane_ctl[g*DW +: DW] = slot_q[g+1];
  end

  p_latch_r2: assert property (@(posedge clk) disable iff (rst)
    (fall && ten_s && !clr_s) |=> code_q == $past(din_s));

  p_keep_code_r4: assert property (@(posedge clk) disable iff (rst)
    (!clr_s && !(fall && ten_s)) |=> $stable(code_q));

  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    clr_s |=> (code_q == '0 && clk_lane_ctl == '0 && settle_ctl == '0 && data_lane_ctl == '0));

  for (genvar g = 0; g < NS; g++) begin : g_chk
    p_write_r3: assert property (@(posedge clk) disable iff (rst)
      (rise && !ten_s && !clr_s && sel == SLOT_W'(g)) |=> slot_q[g] == $past(din_s));
    p_no_stray_r6: assert property (@(posedge clk) disable iff (rst)
      (!clr_s && !(rise && !ten_s && sel == SLOT_W'(g))) |=> $stable(slot_q[g]));
  end
endmodule

// File: rtl/tport_master.sv
module tport_master
  import tport_pkg::*;
#(
  parameter int DW   = BYTE_W,
  parameter int HOLD = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [DW-1:0] req_code,
  input  logic [DW-1:0] req_data,
  output logic          req_ready,
  output logic          tclk_o,
  output logic          ten_o,
  output logic [DW-1:0] tdin_o
);
  localparam int HCW    = $clog2(HOLD + 1);
  localparam int NSTEPS = 6;
  localparam int STW    = $clog2(NSTEPS);

  typedef enum logic {M_IDLE, M_RUN} mst_state_e;

  mst_state_e     state_q;
  logic [HCW-1:0] hold_q;
  logic [STW-1:0] step_q;
  logic [DW-1:0]  data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= M_IDLE;
      hold_q  <= '0;
      step_q  <= '0;
      data_q  <= '0;
      tclk_o  <= 1'b1;
      ten_o   <= 1'b0;
      tdin_o  <= '0;
    end else if (state_q == M_IDLE) begin
      if (req_valid) begin
        state_q <= M_RUN;
        tdin_o  <= req_code;
        data_q  <= req_data;
        hold_q  <= '0;
        step_q  <= '0;
      end
    end else if (hold_q != HCW'(HOLD - 1)) begin
      hold_q <= hold_q + 1'b1;
    end else begin
      hold_q <= '0;
      step_q <= step_q + 1'b1;
      case (step_q)
        STW'(0): ten_o   <= 1'b1;
        STW'(1): tclk_o  <= 1'b0;
        STW'(2): ten_o   <= 1'b0;
        STW'(3): tdin_o  <= data_q;
        STW'(4): tclk_o  <= 1'b1;
        default: state_q <= M_IDLE;
      endcase
    end
  end

  assign req_ready = (state_q == M_IDLE);

  p_one_pin_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($stable(tclk_o) || $stable(ten_o)));

  p_rest_r10: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (tclk_o && !ten_o));

  p_accept_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
endmodule

// File: rtl/tport_if.sv
module tport_if
  import tport_pkg::*;
#(
  parameter int DW          = BYTE_W,
  parameter int LANES       = N_LANES,
  parameter int SYNC_STAGES = 2,
  parameter int HOLD        = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [DW-1:0]       req_code,
  input  logic [DW-1:0]       req_data,
  output logic                req_ready,
  output logic                m_tclk,
  output logic                m_ten,
  output logic [DW-1:0]       m_tdin,
  input  logic                s_tclr,
  input  logic                s_tclk,
  input  logic                s_ten,
  input  logic [DW-1:0]       s_tdin,
  output logic [DW-1:0]       s_tdout,
  output logic [DW-1:0]       clk_lane_ctl,
  output logic [LANES*DW-1:0] data_lane_ctl,
  output logic [DW-1:0]       settle_ctl,
  output logic                normal_op
);
  localparam int PW = DW + 3;
  localparam logic [PW-1:0] PIN_REST = {1'b0, 1'b1, 1'b0, {DW{1'b0}}};

  logic [PW-1:0] pins_s;

  tport_sync #(.W(PW), .STAGES(SYNC_STAGES), .RST_VAL(PIN_REST)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({s_tclr, s_tclk, s_ten, s_tdin}),
    .q   (pins_s)
  );

  tport_bank #(.DW(DW), .LANES(LANES)) i_bank (
    .clk           (clk),
    .rst           (rst),
    .clr_s         (pins_s[DW+2]),
    .tclk_s        (pins_s[DW+1]),
    .ten_s         (pins_s[DW]),
    .din_s         (pins_s[DW-1:0]),
    .tdout         (s_tdout),
    .clk_lane_ctl  (clk_lane_ctl),
    .data_lane_ctl (data_lane_ctl),
    .settle_ctl    (settle_ctl),
    .normal_op     (normal_op)
  );

  tport_master #(.DW(DW), .HOLD(HOLD)) i_master (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_code  (req_code),
    .req_data  (req_data),
    .req_ready (req_ready),
    .tclk_o    (m_tclk),
    .ten_o     (m_ten),
    .tdin_o    (m_tdin)
  );
endmodule

// File: tb/test_tport_if.sv
module test_tport_if;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int LANES = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [DW-1:0] req_code = '0, req_data = '0;
  logic req_ready, m_tclk, m_ten;
  logic [DW-1:0] m_tdin;
  logic use_direct = 1'b0;
  logic d_tclr = 1'b0, d_tclk = 1'b1, d_ten = 1'b0;
  logic [DW-1:0] d_tdin = '0;
  logic s_tclk, s_ten;
  logic [DW-1:0] s_tdin, s_tdout, clk_lane_ctl, settle_ctl;
  logic [LANES*DW-1:0] data_lane_ctl;
  logic normal_op;

  int n_checks = 0;
  int n_fails  = 0;
  logic [DW-1:0] exp_reg [6];
  logic [DW-1:0] exp_code;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign s_tclk = use_direct ? d_tclk : m_tclk;
  assign s_ten  = use_direct ? d_ten  : m_ten;
  assign s_tdin = use_direct ? d_tdin : m_tdin;

  tport_if i_tport_if (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_code(req_code), .req_data(req_data),
    .req_ready(req_ready), .m_tclk(m_tclk), .m_ten(m_ten), .m_tdin(m_tdin),
    .s_tclr(d_tclr), .s_tclk(s_tclk), .s_ten(s_ten), .s_tdin(s_tdin),
    .s_tdout(s_tdout), .clk_lane_ctl(clk_lane_ctl), .data_lane_ctl(data_lane_ctl),
    .settle_ctl(settle_ctl), .normal_op(normal_op)
  );

  function automatic int slot_of(input logic [DW-1:0] c);
    case (c)
      8'h34: return 0;
      8'h44: return 1;
      8'h54: return 2;
      8'h84: return 3;
      8'h94: return 4;
      8'h75: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [DW-1:0] exp_read();
    int s = slot_of(exp_code);
    return (s < 0) ? '0 : exp_reg[s];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check({req, " clock-lane reg R5"}, 32'(clk_lane_ctl), 32'(exp_reg[0]));
    check({req, " data-lane regs R5"}, data_lane_ctl,
          {exp_reg[4], exp_reg[3], exp_reg[2], exp_reg[1]});
    check({req, " settle reg R5"}, 32'(settle_ctl), 32'(exp_reg[5]));
    check({req, " read bus R6"}, 32'(s_tdout), 32'(exp_read()));
    check({req, " normal flag R8"}, 32'(normal_op), 32'(exp_code == 8'h00));
  endtask

  task automatic master_write(input logic [DW-1:0] code, input logic [DW-1:0] data);
    int ev = 0;
    int bad = 0;
    int guard = 0;
    logic pt = 1'b1, pe = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b1; req_code = code; req_data = data;
    @(posedge clk); #1;
    req_valid = 1'b0;
    @(negedge clk);
    check("master busy after accept R10", 32'(req_ready), 32'(0));
    while (!req_ready && guard < 200) begin
      if (m_ten && !pe)        begin if (ev != 0) bad++; ev++; end
      if (!m_tclk && pt)       begin if (ev != 1 || m_tdin != code) bad++; ev++; end
      if (!m_ten && pe)        begin if (ev != 2) bad++; ev++; end
      if (m_tclk && !pt)       begin if (ev != 3 || m_tdin != data) bad++; ev++; end
      pt = m_tclk; pe = m_ten;
      guard++;
      @(negedge clk);
    end
    check("pin event order R9", 32'(bad), 32'(0));
    check("pin event count R9", 32'(ev), 32'(4));
    check("master rest levels R10", {30'(0), m_tclk, m_ten}, 32'b10);
    repeat (8) @(negedge clk);
    exp_code = code;
    if (slot_of(code) >= 0) exp_reg[slot_of(code)] = data;
  endtask

  task automatic pins(input logic t, input logic e, input logic [DW-1:0] d);
    @(posedge clk); #1;
    d_tdin = d; d_ten = e; d_tclk = t;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] codes [7];
    codes[0] = 8'h34; codes[1] = 8'h44; codes[2] = 8'h54; codes[3] = 8'h84;
    codes[4] = 8'h94; codes[5] = 8'h75; codes[6] = 8'h00;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 6; i++) exp_reg[i] = '0;
    exp_code = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check_state("reset R1");
    check("reset ready R1", 32'(req_ready), 32'(1));
    check("reset pins R1", {30'(0), m_tclk, m_ten}, 32'b10);

    // R5 / R3: each implemented code once
    for (int i = 0; i < 6; i++) begin
      master_write(codes[i], 8'(8'h11 * (i + 1)));
      check_state("directed write R3");
    end

    // R6: unimplemented code, write dropped
    master_write(8'h35, 8'hAA);
    check_state("unused code R6");

    // R8: normal operation code
    master_write(8'h00, 8'h5C);
    check_state("normal code R8");

    // R4: fall with enable low, rise with enable high
    use_direct = 1'b1;
    pins(1'b0, 1'b0, 8'h44);
    check_state("no latch with enable low R4");
    pins(1'b0, 1'b1, 8'h99);
    pins(1'b1, 1'b1, 8'h99);
    check_state("no write with enable high R4");
    pins(1'b1, 1'b0, 8'h99);

    // R2: code latch via pins, then write
    pins(1'b1, 1'b1, 8'h54);
    pins(1'b0, 1'b1, 8'h54);
    exp_code = 8'h54;
    check_state("code latch R2");
    pins(1'b0, 1'b0, 8'h3C);
    pins(1'b1, 1'b0, 8'h3C);
    exp_reg[2] = 8'h3C;
    check_state("pin write R3");

    // R7: clear pulse
    @(posedge clk); #1 d_tclr = 1'b1;
    repeat (6) @(negedge clk);
    @(posedge clk); #1 d_tclr = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < 6; i++) exp_reg[i] = '0;
    exp_code = '0;
    check_state("test clear R7");
    use_direct = 1'b0;
    repeat (4) @(negedge clk);

    // random writes: R2 R3 R5 R6 R8
    for (int n = 0; n < 150; n++) begin
      logic [DW-1:0] c;
      if ($urandom_range(3) != 0) c = codes[$urandom_range(6)];
      else c = 8'($urandom);
      master_write(c, 8'($urandom));
      check_state("random write R3");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule